// File: doc/BRIEF.md
# Tone and Melody Sequencer

This block produces the linear samples for up to seven call-progress tone generators and one melody generator, each running at one step per 8 kHz frame. Every generator holds a short list of note entries, each entry made of an 8-bit compressed frequency code and an 8-bit duration code. While a generator is active, its phase accumulator advances by the decoded linear step on every frame tick. The current note is held for its programmed number of duration units, after which the generator moves to the next entry. A list ends either at an end marker or at its last slot, and it then loops back to the first entry until the generator is stopped.

Output slots are served one request at a time. The low three bits of the requested channel number select the generator: 0 is the melody and 1 to 7 are the tones. The sample is taken from a quarter-wave sine table that is folded to a full cycle, and it appears one clock after the request. The melody can be switched to a square wave of equal RMS level. Companding and gain belong to the stage downstream.

Top module: `tone_seq`

## Requirements
- R1: After reset, `smp_valid` and `smp` are 0, and every generator is idle, so a request returns a valid sample of 0.
- R2: A request on `req_chan` is answered exactly one clock later with `smp_valid`=1. The sample comes from generator `req_chan` mod 8 (0 = melody, 1..7 = tones). Without a request, `smp_valid` is 0 and `smp` is 0.
- R3: A start command sets the phase to 0. Each frame tick adds the current linear step to the phase, modulo 2048. The sine sample equals round(SINE_PEAK × sin(2π·phase/2048)) within ±8 LSB and never exceeds SINE_PEAK in magnitude.
- R4: For the melody and tones 1–6, code c decodes to a linear step as follows: 0x01–0x3F gives 64+c; 0x40–0x7F gives 2c; 0x80–0xBF gives 4(c−64); 0xC0–0xFE gives 8(c−128).
- R5: For tone 7 only, codes 0x01–0x3F decode to a linear step of c. Its other ranges follow R4.
- R6: Code 0x00 is a pause. The output is 0 and the phase does not move while the pause lasts.
- R7: A note with duration code d lasts d × FRAMES_PER_UNIT frame ticks. A code of 0 behaves as 1.
- R8: After the note that precedes a code 0xFF entry, the list wraps to entry 0. A list with no marker wraps after its last slot (slot 3 for tones, slot 31 for the melody).
- R9: A stop command silences the generator. A later start resumes from entry 0 with phase 0 and cleared duration counters.
- R10: When `melody_square`=1, the melody outputs +SQ for phase < 1024 and −SQ otherwise, where SQ = round(SINE_PEAK × 181/256). Tones are unaffected by this input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-clock pulse per 8 kHz frame |
| wr_en | input | 1 | Write one list entry |
| wr_gen | input | 3 | Generator written (0 melody, 1..7 tones) |
| wr_idx | input | 5 | Entry index in the list |
| wr_step | input | 8 | Compressed frequency code (0x00 pause, 0xFF end) |
| wr_dur | input | 8 | Duration in units of FRAMES_PER_UNIT frames |
| start_en | input | 1 | Start generator `ctl_gen` from entry 0 |
| stop_en | input | 1 | Stop generator `ctl_gen` (wins over start) |
| ctl_gen | input | 3 | Generator addressed by start/stop |
| melody_square | input | 1 | Square-wave melody select |
| req_valid | input | 1 | Sample request for one channel slot |
| req_chan | input | 6 | Channel number of the request |
| smp_valid | output | 1 | Sample valid, one clock after the request |
| smp | output | 14 | Signed linear sample |

## Verification
The bench sweeps every range boundary of the frequency code, including the narrow tone-7 range. A decoder that uses the wrong base or shift would produce a phase in the wrong quadrant and a sample far from the expected sine. Phase is checked in all four quadrants, including the exact negative peak, which exposes a fold that mirrors the address off by one or forgets the sign. The bench also runs a two-unit note followed by a fast note, runs a pause between two notes, and runs a full four-entry tone list. A design that miscounts duration, lets the phase drift during a pause, or fails to wrap at the marker or at the last slot would land on a different phase. Stop and restart must bring the phase back to zero. The square melody must hold its fixed level while a tone at the same phase stays sinusoidal.

// File: rtl/tone_seq_pkg.sv
package tone_seq_pkg;

   localparam logic [7:0] CODE_PAUSE = 8'h00;
   localparam logic [7:0] CODE_END   = 8'hFF;
   localparam int         LIN_W      = 10;

   typedef struct packed {
      logic [7:0] step;
      logic [7:0] dur;
   } note_t;

   // piecewise expansion of the compressed code to a linear phase step
   function automatic logic [LIN_W-1:0] decode_step(input logic [7:0] code,
                                                    input logic       narrow);
      logic [LIN_W-1:0] mant;
      mant = {4'd1, code[5:0]};
      unique case (code[7:6])
         2'b00:   decode_step = narrow ? {4'd0, code[5:0]} : mant;
         2'b01:   decode_step = {mant[8:0], 1'b0};
         2'b10:   decode_step = {mant[7:0], 2'b00};
         default: decode_step = {mant[6:0], 3'b000};
      endcase
   endfunction

   // rational sine approximation for quarter-table entry i
   function automatic longint quarter_val(input int i, input int qpts, input int peak);
      longint h, u, prod, num, den;
      h    = 2 * longint'(qpts);
      u    = longint'(i);
      prod = u * (h - u);
      num  = 16 * longint'(peak) * prod;
      den  = 5 * h * h - 4 * prod;
      return (num + den / 2) / den;
   endfunction

   function automatic int square_level(input int peak);
      return (peak * 181 + 128) / 256;
   endfunction

endpackage

// File: rtl/tone_seq_gen.sv
module tone_seq_gen
   import tone_seq_pkg::*;
#(
   parameter int DEPTH           = 4,
   parameter bit NARROW          = 1'b0,
   parameter int PHASE_W         = 11,
   parameter int FRAMES_PER_UNIT = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_tick,
   input  logic               wr_en,
   input  logic [4:0]         wr_idx,
   input  note_t              wr_note,
   input  logic               start,
   input  logic               stop,
   output logic [PHASE_W-1:0] phase,
   output logic               audible
);

   localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int SUB_W = (FRAMES_PER_UNIT > 1) ? $clog2(FRAMES_PER_UNIT) : 1;

   note_t              mem [DEPTH];
   logic               active;
   logic [IW-1:0]      idx;
   logic [IW-1:0]      nxt;
   logic [SUB_W-1:0]   sub;
   logic [7:0]         units;
   note_t              cur;
   logic               cur_end, cur_pause, last, wrap, sub_last, note_done;
   logic [LIN_W-1:0]   lin;

   always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_idx) < DEPTH))
         mem[wr_idx[IW-1:0]] <= wr_note;
   end

   always_comb begin
      cur       = mem[idx];
      cur_end   = (cur.step == CODE_END);
      cur_pause = (cur.step == CODE_PAUSE);
      last      = (idx == IW'(DEPTH - 1));
      nxt       = last ? '0 : idx + 1'b1;
      wrap      = last || (mem[nxt].step == CODE_END);
      sub_last  = (sub == SUB_W'(FRAMES_PER_UNIT - 1));
      note_done = ({1'b0, units} + 9'd1) >= {1'b0, cur.dur};
      lin       = (cur_end || cur_pause) ? '0 : decode_step(cur.step, NARROW);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || stop) begin
         active <= 1'b0;
         idx    <= '0;
         sub    <= '0;
         units  <= '0;
         phase  <= '0;
      end else if (start) begin
         active <= 1'b1;
         idx    <= '0;
         sub    <= '0;
         units  <= '0;
         phase  <= '0;
      end else if (active && frame_tick) begin
         phase <= phase + PHASE_W'(lin);
         if (sub_last) begin
            sub <= '0;
            if (note_done) begin
               units <= '0;
               idx   <= wrap ? '0 : nxt;
            end else begin
               units <= units + 8'd1;
            end
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end

   assign audible = active && !cur_end && !cur_pause;

endmodule

// File: rtl/tone_seq_wave.sv
module tone_seq_wave
   import tone_seq_pkg::*;
#(
   parameter int PHASE_W   = 11,
   parameter int SAMPLE_W  = 14,
   parameter int SINE_PEAK = 2896,
   parameter bit SQUARE_EN = 1'b1
) (
   input  logic [PHASE_W-1:0]         phase,
   input  logic                       square,
   output logic signed [SAMPLE_W-1:0] sample
);

   localparam int QPTS = 2 ** (PHASE_W - 2);
   localparam int SQ   = square_level(SINE_PEAK);

   logic signed [SAMPLE_W-1:0] qtab [QPTS+1];
   logic [1:0]                 quad;
   logic [PHASE_W-3:0]         ofs;
   logic [PHASE_W-2:0]         addr;
   logic signed [SAMPLE_W-1:0] mag, sine;

   for (genvar i = 0; i <= QPTS; i++) begin : g_qtab
      assign qtab[i] = SAMPLE_W'(quarter_val(i, QPTS, SINE_PEAK));
   end

   always_comb begin
      quad = phase[PHASE_W-1 -: 2];
      ofs  = phase[PHASE_W-3:0];
      addr = quad[0] ? ((PHASE_W-1)'(QPTS) - {1'b0, ofs}) : {1'b0, ofs};
      mag  = qtab[addr];
      sine = quad[1] ? -mag : mag;
   end

   if (SQUARE_EN) begin : g_square
      assign sample = square ? (quad[1] ? -SAMPLE_W'(SQ) : SAMPLE_W'(SQ)) : sine;
   end else begin : g_sine_only
      logic unused_sq;
      assign unused_sq = square;
      assign sample    = sine;
   end

endmodule

// File: rtl/tone_seq.sv
module tone_seq
   import tone_seq_pkg::*;
#(
   parameter int TONE_DEPTH      = 4,
   parameter int MELODY_DEPTH    = 32,
   parameter int PHASE_W         = 11,
   parameter int SAMPLE_W        = 14,
   parameter int SINE_PEAK       = 2896,
   parameter int FRAMES_PER_UNIT = 256,
   parameter bit SQUARE_EN       = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_tick,
   input  logic                       wr_en,
   input  logic [2:0]                 wr_gen,
   input  logic [4:0]                 wr_idx,
   input  logic [7:0]                 wr_step,
   input  logic [7:0]                 wr_dur,
   input  logic                       start_en,
   input  logic                       stop_en,
   input  logic [2:0]                 ctl_gen,
   input  logic                       melody_square,
   input  logic                       req_valid,
   input  logic [5:0]                 req_chan,
   output logic                       smp_valid,
   output logic signed [SAMPLE_W-1:0] smp
);

   localparam int GENS   = 8;
   localparam int GEN_W  = $clog2(GENS);
   localparam int CHAN_W = 6;

   if (TONE_DEPTH < 1 || TONE_DEPTH > 32 || MELODY_DEPTH < 1 || MELODY_DEPTH > 32) begin : g_bad_depth
      $error("list depth must lie in 1..32");
   end
   if (PHASE_W < LIN_W + 1) begin : g_bad_phase
      $error("phase accumulator narrower than the linear step");
   end
   if (SINE_PEAK >= 2 ** (SAMPLE_W - 1)) begin : g_bad_peak
      $error("peak does not fit the sample width");
   end
   if (FRAMES_PER_UNIT < 1) begin : g_bad_unit
      $error("duration unit must hold at least one frame");
   end

   logic [PHASE_W-1:0]         ph  [GENS];
   logic                       aud [GENS];
   note_t                      wnote;
   logic [GEN_W-1:0]           sel;
   logic signed [SAMPLE_W-1:0] wave;

   assign wnote = '{step: wr_step, dur: wr_dur};

   for (genvar g = 0; g < GENS; g++) begin : g_gen
      localparam int DEP = (g == 0) ? MELODY_DEPTH : TONE_DEPTH;
      localparam bit NAR = (g == GENS - 1);
      tone_seq_gen #(
         .DEPTH           (DEP),
         .NARROW          (NAR),
         .PHASE_W         (PHASE_W),
         .FRAMES_PER_UNIT (FRAMES_PER_UNIT)
      ) u_gen (
         .clk        (clk),
         .rst_n      (rst_n),
         .frame_tick (frame_tick),
         .wr_en      (wr_en && (wr_gen == GEN_W'(g))),
         .wr_idx     (wr_idx),
         .wr_note    (wnote),
         .start      (start_en && !stop_en && (ctl_gen == GEN_W'(g))),
         .stop       (stop_en && (ctl_gen == GEN_W'(g))),
         .phase      (ph[g]),
         .audible    (aud[g])
      );
   end

   assign sel = GEN_W'(req_chan % CHAN_W'(GENS));

   tone_seq_wave #(
      .PHASE_W   (PHASE_W),
      .SAMPLE_W  (SAMPLE_W),
      .SINE_PEAK (SINE_PEAK),
      .SQUARE_EN (SQUARE_EN)
   ) u_wave (
      .phase  (ph[sel]),
      .square (melody_square && (sel == '0)),
      .sample (wave)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_valid <= 1'b0;
         smp       <= '0;
      end else begin
         smp_valid <= req_valid;
         smp       <= (req_valid && aud[sel]) ? wave : '0;
      end
   end

endmodule

// File: rtl/tone_seq_chk.sv
module tone_seq_chk
   import tone_seq_pkg::*;
#(
   parameter int SINE_PEAK = 2896,
   parameter int SAMPLE_W  = 14
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       req_valid,
   input logic [5:0]                 req_chan,
   input logic                       melody_square,
   input logic                       smp_valid,
   input logic signed [SAMPLE_W-1:0] smp
);

   localparam int SQ = square_level(SINE_PEAK);

   logic [SAMPLE_W-1:0] mag;
   logic                melody_req;

   assign mag        = smp[SAMPLE_W-1] ? (~smp + 1'b1) : smp;
   assign melody_req = ((req_chan % 6'd8) == 6'd0);

   AST_ONE_CYCLE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (smp_valid == $past(req_valid)));                          // R2

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |-> (smp == '0));                                        // R1

   AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> (mag <= SAMPLE_W'(SINE_PEAK)));                       // R3

   AST_SQUARE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && $past(melody_square) && $past(melody_req) && (smp != '0))
         |-> (mag == SAMPLE_W'(SQ)));                                     // R10

endmodule

bind tone_seq tone_seq_chk #(
   .SINE_PEAK (SINE_PEAK),
   .SAMPLE_W  (SAMPLE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_chan      (req_chan),
   .melody_square (melody_square),
   .smp_valid     (smp_valid),
   .smp           (smp)
);

// File: tb/tone_seq_tb.sv
module tone_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int PEAK       = 2896;
   localparam int SQ         = 2048;
   localparam int TOL        = 8;
   localparam int UNIT       = 4;
   localparam int NVEC       = 11;

   // stimulus table: channel, code, frame ticks
   localparam int V_CHAN [NVEC] = '{9, 18, 27, 4, 45, 54, 8, 56, 15, 63, 17};
   localparam int V_CODE [NVEC] = '{'h01, 'h3F, 'h40, 'h7F, 'h80, 'hBF, 'hC0, 'hFE, 'h05, 'h40, 'hD0};
   localparam int V_TICK [NVEC] = '{3, 5, 7, 9, 5, 3, 3, 5, 10, 2, 1};

   logic clk = 1'b0, rst_n = 1'b0, frame_tick = 1'b0, wr_en = 1'b0;
   logic start_en = 1'b0, stop_en = 1'b0, melody_square = 1'b0, req_valid = 1'b0;
   logic [2:0] wr_gen = '0, ctl_gen = '0;
   logic [4:0] wr_idx = '0;
   logic [7:0] wr_step = '0, wr_dur = '0;
   logic [5:0] req_chan = '0;
   logic smp_valid;
   logic signed [13:0] smp;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tone_seq #(.FRAMES_PER_UNIT(UNIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .wr_en(wr_en), .wr_gen(wr_gen), .wr_idx(wr_idx), .wr_step(wr_step), .wr_dur(wr_dur),
      .start_en(start_en), .stop_en(stop_en), .ctl_gen(ctl_gen),
      .melody_square(melody_square), .req_valid(req_valid), .req_chan(req_chan),
      .smp_valid(smp_valid), .smp(smp)
   );

   task automatic check(input string tag, input int got, input int exp, input int tol);
      checks++;
      if (got > exp + tol || got < exp - tol) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic put(input int g, input int i, input int st, input int du);
      @(negedge clk);
      wr_en = 1'b1; wr_gen = 3'(g); wr_idx = 5'(i); wr_step = 8'(st); wr_dur = 8'(du);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ctl(input int g, input bit stop);
      @(negedge clk);
      ctl_gen = 3'(g); start_en = !stop; stop_en = stop;
      @(negedge clk);
      start_en = 1'b0; stop_en = 1'b0;
   endtask

   task automatic frames(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); frame_tick = 1'b1;
         @(negedge clk); frame_tick = 1'b0;
      end
   endtask

   task automatic probe(input int ch, output int val, output int vld);
      @(negedge clk);
      req_valid = 1'b1; req_chan = 6'(ch);
      @(negedge clk);
      req_valid = 1'b0;
      val = int'(smp);
      vld = int'(smp_valid);
   endtask

   function automatic int lin_step(input int code, input bit narrow);
      if (code < 64)       return narrow ? code : 64 + code;
      else if (code < 128) return 2 * code;
      else if (code < 192) return 4 * (code - 64);
      else                 return 8 * (code - 128);
   endfunction

   function automatic int sine_at(input int p);
      real r;
      r = PEAK * $sin(6.283185307179586 * (p % 2048) / 2048.0);
      return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      int v, vl, ph;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", int'(smp_valid), 0, 0);
      check("R1 sample in reset", int'(smp), 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      probe(3, v, vl);
      check("R2 reply valid", vl, 1, 0);
      check("R1 idle generator", v, 0, 0);
      @(negedge clk);
      check("R2 no request", int'(smp_valid), 0, 0);

      // table walk: decode ranges, channel mapping, quadrant folding
      for (int i = 0; i < NVEC; i++) begin
         int g;
         g = V_CHAN[i] % 8;
         put(g, 0, V_CODE[i], 200);
         put(g, 1, 'hFF, 0);
         ctl(g, 1'b0);
         frames(V_TICK[i]);
         probe(V_CHAN[i], v, vl);
         ph = (V_TICK[i] * lin_step(V_CODE[i], g == 7)) % 2048;
         check($sformatf("%s R3 vec%0d", (g == 7) ? "R5" : "R4", i), v, sine_at(ph), TOL);
         check($sformatf("R2 vec%0d valid", i), vl, 1, 0);
      end

      // R6 pause freezes phase; R8 wrap at end marker
      put(2, 0, 'h40, 1);
      put(2, 1, 'h00, 1);
      put(2, 2, 'hFF, 0);
      ctl(2, 1'b0);
      frames(4);
      probe(2, v, vl);
      check("R6 pause silent", v, 0, 0);
      frames(4);
      probe(10, v, vl);
      check("R6 phase held after pause", v, sine_at(512), TOL);
      frames(1);
      probe(26, v, vl);
      check("R8 wrap at end marker", v, sine_at(640), TOL);

      // R7 two-unit note then fast note
      put(3, 0, 'h40, 2);
      put(3, 1, 'hC0, 1);
      put(3, 2, 'hFF, 0);
      ctl(3, 1'b0);
      frames(7);
      probe(3, v, vl);
      check("R7 inside long note", v, sine_at(896), TOL);
      frames(2);
      probe(35, v, vl);
      check("R7 next note after two units", v, sine_at(1536), TOL);

      // R8 full list without marker
      put(4, 0, 'h40, 1);
      put(4, 1, 'h40, 1);
      put(4, 2, 'h40, 1);
      put(4, 3, 'h80, 1);
      ctl(4, 1'b0);
      frames(17);
      probe(12, v, vl);
      check("R8 wrap after last slot", v, sine_at(640), TOL);

      // R9 stop silences, restart clears phase and index
      ctl(3, 1'b1);
      probe(11, v, vl);
      check("R9 stopped silent", v, 0, 0);
      ctl(3, 1'b0);
      frames(1);
      probe(11, v, vl);
      check("R9 restart from zero", v, sine_at(128), TOL);

      // R10 square melody next to a sine tone
      put(0, 0, 'h40, 50);
      put(0, 1, 'hFF, 0);
      put(1, 0, 'h40, 50);
      put(1, 1, 'hFF, 0);
      melody_square = 1'b1;
      ctl(0, 1'b0);
      ctl(1, 1'b0);
      frames(3);
      probe(0, v, vl);
      check("R10 square high", v, SQ, 0);
      probe(1, v, vl);
      check("R10 tone stays sine", v, sine_at(384), TOL);
      frames(6);
      probe(16, v, vl);
      check("R10 square low", v, -SQ, 0);
      melody_square = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule